// File: doc/BRIEF.md
# Class-Aware Bank Enable Manager

This block keeps a two-bit occupancy code for every bank of a banked, set-associative prefix store. The codes record which prefix class groups a bank holds. Class 0 is the longest-prefix group. Every nonzero class value belongs to the shorter group. During a lookup the store walks through the classes one step at a time. At each step this block returns a mask that wakes only the banks that can hold an entry of the class being searched. Every other bank stays idle.

When a prefix is written into the store, the block chooses the bank that receives it. Long-group prefixes fill banks from the low-index end of the array. Short-group prefixes fill banks from the high-index end. Because the two groups grow from opposite ends, most banks hold a single group, and those banks drop out of the search steps for the other group. The caller supplies a per-bank free-way vector. The block gives back the chosen bank, or a full flag when no bank has a free way. On an accepted insert it updates the chosen bank's code. Deleting entries never narrows a code. A clear input returns every code to empty.

Top module: `bank_enable_mgr`

## Requirements
- R1: After reset every bank code is empty, so `srch_en_o` is all zeros for every search class.
- R2: Codes are 2'b00 empty, 2'b01 long group only, 2'b10 short group only and 2'b11 mixed. Class value 0 is the long group, and any nonzero class value is the short group.
- R3: For class 0, `ins_bank_o` is the lowest bank index whose bit in `ins_free_i` is set. It depends combinationally on the current inputs.
- R4: For a nonzero class, `ins_bank_o` is the highest bank index whose bit in `ins_free_i` is set.
- R5: When `ins_free_i` is all zeros, `ins_full_o` is 1 and `ins_bank_o` is 0. An insert in this state changes no code.
- R6: An accepted insert (`ins_valid_i`=1, not full, no clear) ORs its group bit into the chosen bank's code at the clock edge. The new code is visible on `srch_en_o` after that edge. A long entry placed in a short bank, or a short entry placed in a long bank, makes that bank mixed.
- R7: A search for class 0 enables exactly the banks whose code is long or mixed. A search for a nonzero class enables exactly the banks whose code is short or mixed. Empty banks are never enabled.
- R8: `clear_i` sets every code to empty at the next edge and takes priority over an insert in the same cycle.
- R9: While `ins_valid_i` is 0, no code changes, whatever the class and free inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of all bank codes |
| ins_valid_i | input | 1 | Insert request |
| ins_class_i | input | CLASS_W | Class of the prefix being inserted |
| ins_free_i | input | NUM_BANKS | Per-bank flag: bank has a free way |
| ins_bank_o | output | $clog2(NUM_BANKS) | Chosen bank for the insert |
| ins_full_o | output | 1 | No bank has a free way |
| srch_class_i | input | CLASS_W | Class of the current search step |
| srch_en_o | output | NUM_BANKS | Bank enable mask for the search step |

## Verification
The bench sweeps every free-way vector of an eight-bank array for both class groups. A picker that scanned from the wrong end, or that stopped one bank short, would return the wrong index for some vector. A picker that missed the all-zero case would raise no full flag, or would report a bank other than 0. A long run of inserts is checked against a code model after every edge. A design that overwrote a code instead of merging into it would never reach mixed, so it would drop banks from the search for the other group. A design that ignored valid or full would mark banks that were never written. A clear given in the same cycle as an insert must leave every bank empty; a design that let the insert win would leave the chosen bank enabled.

// File: rtl/bem_pkg.sv
package bem_pkg;

   typedef enum logic [1:0] {
      OCC_EMPTY = 2'b00,
      OCC_LONG  = 2'b01,
      OCC_SHORT = 2'b10,
      OCC_MIXED = 2'b11
   } occ_e;

   // Group bit carried by a class: the long group sets bit 0, the short group sets bit 1.
   function automatic logic [1:0] group_bits(input logic is_long);
      return is_long ? 2'b01 : 2'b10;
   endfunction

endpackage

// File: rtl/bem_first_free.sv
module bem_first_free #(
   parameter int N         = 16,
   parameter bit FROM_HIGH = 1'b0,
   localparam int IDX_W    = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             found_o
);

   if (N < 2) begin : g_bad_n
      $error("bem_first_free: N must be at least 2");
   end

   always_comb begin
      idx_o   = '0;
      found_o = 1'b0;
      for (int k = 0; k < N; k++) begin
         int b;
         b = FROM_HIGH ? (N - 1 - k) : k;
         if (!found_o && req_i[b]) begin
            idx_o   = IDX_W'(b);
            found_o = 1'b1;
         end
      end
   end

   // a_r5_none_found_means_empty: when nothing is free, the index reads zero.
   always_comb begin
      if (!found_o) a_r5_idle_index : assert (idx_o == '0);
   end

endmodule

// File: rtl/bem_bank_code.sv
module bem_bank_code
   import bem_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear_i,
   input  logic       we_i,
   input  logic [1:0] grp_i,
   output logic [1:0] code_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       code_o <= OCC_EMPTY;
      else if (clear_i) code_o <= OCC_EMPTY;
      else if (we_i)    code_o <= code_o | grp_i;
   end

   // R6: without a clear, a code keeps every bit it already had.
   a_r6_code_never_narrows : assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> ((code_o & $past(code_o)) == $past(code_o)));

   // R8: clear empties the bank at the next edge.
   a_r8_clear_empties : assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (code_o == OCC_EMPTY));

   // R9: with no write and no clear, the code holds.
   a_r9_hold_when_idle : assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && !we_i) |=> $stable(code_o));

endmodule

// File: rtl/bank_enable_mgr.sv
module bank_enable_mgr
   import bem_pkg::*;
#(
   parameter int NUM_BANKS = 16,
   parameter int CLASS_W   = 2,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clear_i,
   input  logic                 ins_valid_i,
   input  logic [CLASS_W-1:0]   ins_class_i,
   input  logic [NUM_BANKS-1:0] ins_free_i,
   output logic [BANK_W-1:0]    ins_bank_o,
   output logic                 ins_full_o,
   input  logic [CLASS_W-1:0]   srch_class_i,
   output logic [NUM_BANKS-1:0] srch_en_o
);

   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("bank_enable_mgr: NUM_BANKS must be at least 2");
   end
   if (CLASS_W < 1) begin : g_bad_class
      $error("bank_enable_mgr: CLASS_W must be at least 1");
   end

   logic [BANK_W-1:0] lo_idx, hi_idx;
   logic              lo_found, hi_found;
   logic              ins_is_long, pick_found;
   logic [1:0]        ins_grp, srch_grp;
   logic [1:0]        codes [NUM_BANKS];

   // Long group fills from bank 0 upward, short group from the top bank downward.
   bem_first_free #(.N(NUM_BANKS), .FROM_HIGH(1'b0)) u_pick_lo (
      .req_i   (ins_free_i),
      .idx_o   (lo_idx),
      .found_o (lo_found)
   );

   bem_first_free #(.N(NUM_BANKS), .FROM_HIGH(1'b1)) u_pick_hi (
      .req_i   (ins_free_i),
      .idx_o   (hi_idx),
      .found_o (hi_found)
   );

   assign ins_is_long = (ins_class_i == '0);
   assign ins_grp     = group_bits(ins_is_long);
   assign srch_grp    = group_bits(srch_class_i == '0);
   assign pick_found  = ins_is_long ? lo_found : hi_found;
   assign ins_bank_o  = ins_is_long ? lo_idx : hi_idx;
   assign ins_full_o  = !pick_found;

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      logic we;
      assign we = ins_valid_i && pick_found && (ins_bank_o == BANK_W'(i));

      bem_bank_code u_code (
         .clk     (clk),
         .rst_n   (rst_n),
         .clear_i (clear_i),
         .we_i    (we),
         .grp_i   (ins_grp),
         .code_o  (codes[i])
      );

      assign srch_en_o[i] = |(codes[i] & srch_grp);
   end

   // R5: the full flag is raised only when no bank offers a free way.
   a_r5_full_only_when_none_free : assert property (@(posedge clk) disable iff (!rst_n)
      ins_full_o |-> (ins_free_i == '0));

   // R3 and R4: the chosen bank always offers a free way.
   a_r3_pick_is_free : assert property (@(posedge clk) disable iff (!rst_n)
      !ins_full_o |-> ins_free_i[ins_bank_o]);

   // R6: an accepted insert leaves its group bit in the chosen bank.
   a_r6_insert_marks_bank : assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid_i && !ins_full_o && !clear_i) |=>
         ((codes[$past(ins_bank_o)] & $past(ins_grp)) != 2'b00));

   // R7: an enabled bank is never empty.
   for (genvar j = 0; j < NUM_BANKS; j++) begin : g_chk
      a_r7_no_empty_enable : assert property (@(posedge clk) disable iff (!rst_n)
         srch_en_o[j] |-> (codes[j] != OCC_EMPTY));
   end

endmodule

// File: tb/bank_enable_mgr_test.sv
`timescale 1ns/100ps
module bank_enable_mgr_test;

   localparam int NB = 8;
   localparam int BW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clear_i = 1'b0;
   logic          ins_valid_i = 1'b0;
   logic [1:0]    ins_class_i = '0;
   logic [NB-1:0] ins_free_i = '0;
   logic [BW-1:0] ins_bank_o;
   logic          ins_full_o;
   logic [1:0]    srch_class_i = '0;
   logic [NB-1:0] srch_en_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic [1:0] m [NB];

   always #2 clk = ~clk;

   bank_enable_mgr #(.NUM_BANKS(NB), .CLASS_W(2)) uut (
      .clk, .rst_n, .clear_i, .ins_valid_i, .ins_class_i, .ins_free_i,
      .ins_bank_o, .ins_full_o, .srch_class_i, .srch_en_o
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_bank(input logic [1:0] cls, input logic [NB-1:0] fr);
      if (cls == 0) begin
         for (int b = 0; b < NB; b++) if (fr[b]) return b;
      end else begin
         for (int b = NB - 1; b >= 0; b--) if (fr[b]) return b;
      end
      return -1;
   endfunction

   // R7: expected enables from the model codes.
   task automatic check_enables(input string req);
      for (int c = 0; c < 3; c++) begin
         logic [NB-1:0] e;
         srch_class_i = 2'(c);
         #0.2;
         for (int b = 0; b < NB; b++) e[b] = |(m[b] & ((c == 0) ? 2'b01 : 2'b10));
         check(srch_en_o == e, req, srch_en_o, e);
      end
   endtask

   // Drive at the falling edge, check the pick, then take one rising edge.
   task automatic step(input bit v, input bit clr, input logic [1:0] cls, input logic [NB-1:0] fr);
      int eb;
      @(negedge clk);
      ins_valid_i = v; clear_i = clr; ins_class_i = cls; ins_free_i = fr;
      #0.3;
      eb = exp_bank(cls, fr);
      if (eb < 0) begin
         check(ins_full_o == 1'b1 && ins_bank_o == 0, "R5", {ins_full_o, ins_bank_o}, 8);
      end else begin
         check(ins_full_o == 1'b0 && ins_bank_o == BW'(eb), (cls == 0) ? "R3" : "R4",
               {ins_full_o, ins_bank_o}, eb);
      end
      @(posedge clk);
      if (clr) begin
         for (int b = 0; b < NB; b++) m[b] = 2'b00;
      end else if (v && eb >= 0) begin
         m[eb] = m[eb] | ((cls == 0) ? 2'b01 : 2'b10);
      end
      @(negedge clk);
      ins_valid_i = 1'b0; clear_i = 1'b0;
      check_enables(clr ? "R8" : (v ? "R6" : "R9"));
   endtask

   initial begin
      #400000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int b = 0; b < NB; b++) m[b] = 2'b00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: all banks empty after reset.
      check_enables("R1");

      // R3 R4 R5: exhaustive free-vector sweep for both groups, no insert.
      for (int c = 0; c < 3; c += 2) begin
         for (int f = 0; f < (1 << NB); f++) begin
            int eb;
            ins_class_i = 2'(c); ins_free_i = NB'(f);
            #0.1;
            eb = exp_bank(2'(c), NB'(f));
            if (eb < 0)
               check(ins_full_o && ins_bank_o == 0, "R5", {ins_full_o, ins_bank_o}, 8);
            else
               check(!ins_full_o && ins_bank_o == BW'(eb), (c == 0) ? "R3" : "R4",
                     {ins_full_o, ins_bank_o}, eb);
         end
      end
      @(negedge clk);

      // R6 R2: a long entry lands in bank 0, a short one in bank 7, then each
      // group lands in the other's bank, which becomes mixed.
      step(1, 0, 2'd0, 8'b0000_0001);
      step(1, 0, 2'd1, 8'b1000_0000);
      step(1, 0, 2'd2, 8'b0000_0001);
      step(1, 0, 2'd0, 8'b1000_0000);
      check(m[0] == 2'b11 && m[7] == 2'b11, "R6", {m[0], m[7]}, 4'hf);
      // R5: an insert with nothing free changes no code.
      step(1, 0, 2'd0, 8'b0);
      step(1, 0, 2'd3, 8'b0);
      // R9: invalid requests with free banks change nothing.
      step(0, 0, 2'd0, 8'b0111_1110);
      step(0, 0, 2'd2, 8'b0111_1110);
      // R8: clear beats a simultaneous insert.
      step(1, 1, 2'd0, 8'b0000_0100);

      // Mixed random run against the model.
      for (int n = 0; n < 300; n++) begin
         logic [NB-1:0] fr;
         logic [1:0] cl;
         fr = NB'($urandom);
         if ((n % 7) == 3) fr = '0;
         cl = 2'($urandom % 4);
         step(($urandom % 5) != 0, (n % 97) == 50, cl, fr);
      end

      // R8: a final clear empties every bank.
      step(0, 1, 2'd0, 8'hff);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule